// File: doc/BRIEF.md
# Pipelined DC-Balanced Byte-to-Ten-Bit Line Encoder

This block turns one byte per clock into a 10-bit code word whose ones and zeros stay in balance over time. It suits a multi-level serial link that needs a DC-free symbol stream. The low five bits of a byte become a 6-bit sub-block and the high three bits become a 4-bit sub-block. Each sub-block comes from its own lookup. Bytes whose low field falls outside the 6-bit lookup take a joint path instead, and that path emits a 6-bit sub-block with a disparity of four. A control flag switches to a small table of eight special characters.

A 2-bit running disparity decides whether each unbalanced sub-block is sent in its ones-heavy form or its zeros-heavy form, and it is updated from the disparity of the word actually sent. After reset, the first word takes its starting disparity from an external 2-bit value. A valid bit travels alongside each byte. Cycles without a byte leave the running disparity and the outputs untouched. Every byte appears at the output a fixed four clock edges after it is captured.

Top module: `pse_encoder`

## Requirements
- R1: While `rst_n` is low, `valid_o` is 0, `code_o` is 0 and `rd_o` is 2'b01. The pipeline leaves reset on the second rising edge after `rst_n` rises.
- R2: A byte presented with `valid_i` high at a rising edge appears with `valid_o` high after the fourth rising edge, counting the capture edge as the first. One byte is accepted on every cycle.
- R3: The running disparity is coded 2'b00 = -2, 2'b01 = 0, 2'b10 = +2, 2'b11 = +4. The first valid word after reset starts from `rd_init_i`. After each word, `rd_o` equals the disparity before that word plus the word's disparity (ones minus zeros of `code_o`).
- R4: When the disparity before a word is -2 or 0, every unbalanced sub-block is sent in its ones-heavy form. When it is +2 or +4, every unbalanced sub-block is sent complemented. A balanced sub-block is never complemented.
- R5: For a data byte with v = `data_i[4:0]` below 28, the ones-heavy `code_o[9:4]` is the v-th 6-bit word (ascending, counted from 0) with three ones when v < 20, and otherwise the (v-20)-th 6-bit word with four ones.
- R6: For such a byte with h = `data_i[7:5]`, the ones-heavy `code_o[3:0]` is the h-th 4-bit word with two ones when h < 6, and otherwise the (h-6)-th 4-bit word with three ones.
- R7: For a data byte with v >= 28, let n = (v-28)*8 + h. The ones-heavy `code_o[9:4]` is the (n/6)-th 6-bit word with five ones, and `code_o[3:0]` is the (n mod 6)-th 4-bit word with two ones.
- R8: With `ctrl_i` high, only c = `data_i[2:0]` matters. The ones-heavy `code_o[9:4]` is the complement of the (8 + c/4)-th 6-bit word with four ones, and `code_o[3:0]` is the (c mod 4)-th 4-bit word with three ones. `data_i[7:3]` has no effect.
- R9: A cycle with `valid_i` low yields `valid_o` low four edges later. On that cycle `code_o` and `rd_o` hold their previous values, and the running disparity does not change.
- R10: Every emitted 6-bit sub-block has 1 to 5 ones and every 4-bit sub-block has 1 to 3 ones, so each sub-block disparity is 0, ±2 or ±4. The cumulative disparity of the stream, starting from `rd_init_i`, never leaves the range -2 to +4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Byte-rate clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| valid_i | input | 1 | A byte is presented this cycle |
| ctrl_i | input | 1 | 1 = special character, 0 = data byte |
| data_i | input | 8 | Byte to encode |
| rd_init_i | input | 2 | Starting running disparity for the first word after reset |
| valid_o | output | 1 | `code_o` carries a new word |
| code_o | output | 10 | Code word: [9:4] from the low field, [3:0] from the high field |
| rd_o | output | 2 | Running disparity after the word on `code_o` |

## Verification
The assertions take for granted that `rd_init_i` is stable from the start of reset until the first byte has passed the disparity stage. They also assume `valid_i` is low or at least known during reset, and that every input is a known value at each rising edge. The bench sets `rd_init_i` only while `rst_n` is low and keeps `valid_i` low through reset and its release. It changes every input on falling edges only. Word-step and polarity properties are checked only across back-to-back valid words, where the previous `rd_o` is exactly the disparity that the current word started from.

// File: rtl/pse_pkg.sv
package pse_pkg;

  localparam int BYTE_W   = 8;
  localparam int LO_W     = 5;
  localparam int HI_W     = BYTE_W - LO_W;
  localparam int SUB6_W   = 6;
  localparam int SUB4_W   = 4;
  localparam int CODE_W   = SUB6_W + SUB4_W;
  localparam int RD_W     = 2;
  localparam int LO_N     = 1 << LO_W;
  localparam int HI_N     = 1 << HI_W;
  localparam int LO_BAL_N = 20;                 // balanced 6-bit words
  localparam int LO_SPEC  = 28;                 // first low value taking the joint path
  localparam int HI_BAL_N = 6;                  // balanced 4-bit words
  localparam int KC_W     = 3;
  localparam int KC_N     = 1 << KC_W;
  localparam int KC_BASE  = 8;                  // first spare four-ones 6-bit word
  localparam int SPEC_N   = (LO_N - LO_SPEC) * HI_N;

  typedef logic [RD_W-1:0] rd_t;
  localparam rd_t RD_NEG2 = 2'b00;
  localparam rd_t RD_ZERO = 2'b01;
  localparam rd_t RD_POS4 = 2'b11;

  // ones-heavy form of a word, with per-sub-block complement enables
  typedef struct packed {
    logic [SUB6_W-1:0] six;
    logic [SUB4_W-1:0] four;
    logic              flip6;
    logic              flip4;
    logic [1:0]        half_d;   // word disparity / 2 in ones-heavy form
  } pos_word_t;

  // idx-th value (ascending) of width nbits carrying exactly wt ones
  function automatic logic [7:0] nth_word(int nbits, int wt, int idx);
    logic [7:0] r;
    int         seen;
    r    = '0;
    seen = 0;
    for (int v = 0; v < 256; v++) begin
      if (v < (1 << nbits) && $countones(v[7:0]) == wt) begin
        if (seen == idx) r = v[7:0];
        seen++;
      end
    end
    return r;
  endfunction

endpackage

// File: rtl/pse_lookup.sv
module pse_lookup
  import pse_pkg::*;
(
  input  logic [BYTE_W-1:0] byte_i,
  input  logic              ctrl_i,
  output pos_word_t         pw_o
);

  logic [SUB6_W-1:0] lo_tab  [LO_N];
  logic [SUB4_W-1:0] hi_tab  [HI_N];
  logic [SUB6_W-1:0] sp6_tab [SPEC_N];
  logic [SUB4_W-1:0] sp4_tab [SPEC_N];
  logic [SUB6_W-1:0] k6_tab  [KC_N];
  logic [SUB4_W-1:0] k4_tab  [KC_N];

  for (genvar i = 0; i < LO_N; i++) begin : g_lo
    if (i < LO_BAL_N) begin : g_bal
      assign lo_tab[i] = SUB6_W'(nth_word(SUB6_W, 3, i));
    end else if (i < LO_SPEC) begin : g_unb
      assign lo_tab[i] = SUB6_W'(nth_word(SUB6_W, 4, i - LO_BAL_N));
    end else begin : g_none
      assign lo_tab[i] = '0;
    end
  end

  for (genvar i = 0; i < HI_N; i++) begin : g_hi
    if (i < HI_BAL_N) begin : g_bal
      assign hi_tab[i] = SUB4_W'(nth_word(SUB4_W, 2, i));
    end else begin : g_unb
      assign hi_tab[i] = SUB4_W'(nth_word(SUB4_W, 3, i - HI_BAL_N));
    end
  end

  for (genvar n = 0; n < SPEC_N; n++) begin : g_sp
    assign sp6_tab[n] = SUB6_W'(nth_word(SUB6_W, 5, n / 6));
    assign sp4_tab[n] = SUB4_W'(nth_word(SUB4_W, 2, n % 6));
  end

  for (genvar c = 0; c < KC_N; c++) begin : g_k
    assign k6_tab[c] = ~SUB6_W'(nth_word(SUB6_W, 4, KC_BASE + c / 4));
    assign k4_tab[c] = SUB4_W'(nth_word(SUB4_W, 3, c % 4));
  end

  logic [LO_W-1:0] lo;
  logic [HI_W-1:0] hi;
  logic [KC_W-1:0] kc;

  assign lo = byte_i[LO_W-1:0];
  assign hi = byte_i[BYTE_W-1:LO_W];
  assign kc = byte_i[KC_W-1:0];

  always_comb begin
    if (ctrl_i) begin
      pw_o.six    = k6_tab[kc];
      pw_o.four   = k4_tab[kc];
      pw_o.flip6  = 1'b1;
      pw_o.flip4  = 1'b1;
      pw_o.half_d = 2'd0;
    end else if (lo >= LO_W'(LO_SPEC)) begin
      pw_o.six    = sp6_tab[{lo[1:0], hi}];
      pw_o.four   = sp4_tab[{lo[1:0], hi}];
      pw_o.flip6  = 1'b1;
      pw_o.flip4  = 1'b0;
      pw_o.half_d = 2'd2;
    end else begin
      pw_o.six    = lo_tab[lo];
      pw_o.four   = hi_tab[hi];
      pw_o.flip6  = (lo >= LO_W'(LO_BAL_N));
      pw_o.flip4  = (hi >= HI_W'(HI_BAL_N));
      pw_o.half_d = {1'b0, pw_o.flip6} + {1'b0, pw_o.flip4};
    end
  end

endmodule

// File: rtl/pse_rd_track.sv
module pse_rd_track
  import pse_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_i,
  input  rd_t               init_i,
  input  pos_word_t         pw_i,
  output logic [CODE_W-1:0] code_o,
  output rd_t               rd_next_o
);

  rd_t               rd_q, rd_d, cur;
  logic              fresh_q, fresh_d;
  logic              neg;
  logic signed [3:0] sum;

  always_comb begin
    cur    = fresh_q ? init_i : rd_q;
    neg    = cur[1];
    code_o = {(pw_i.flip6 && neg) ? ~pw_i.six  : pw_i.six,
              (pw_i.flip4 && neg) ? ~pw_i.four : pw_i.four};
    if (neg) sum = $signed({2'b00, cur}) - $signed({2'b00, pw_i.half_d});
    else     sum = $signed({2'b00, cur}) + $signed({2'b00, pw_i.half_d});
    if (sum < 0)          rd_next_o = RD_NEG2;
    else if (sum > 4'sd3) rd_next_o = RD_POS4;
    else                  rd_next_o = rd_t'(sum[1:0]);
    rd_d    = en_i ? rd_next_o : rd_q;
    fresh_d = fresh_q && !en_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q    <= RD_ZERO;
      fresh_q <= 1'b1;
    end else begin
      rd_q    <= rd_d;
      fresh_q <= fresh_d;
    end
  end

endmodule

// File: rtl/pse_encoder.sv
module pse_encoder
  import pse_pkg::*;
#(
  parameter int RST_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              valid_i,
  input  logic              ctrl_i,
  input  logic [BYTE_W-1:0] data_i,
  input  logic [RD_W-1:0]   rd_init_i,
  output logic              valid_o,
  output logic [CODE_W-1:0] code_o,
  output logic [RD_W-1:0]   rd_o
);

  // reset release synchronizer
  logic [RST_STAGES-1:0] rsync_q;
  logic                  rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= '0;
    else        rsync_q <= {rsync_q[RST_STAGES-2:0], 1'b1};
  end
  assign rst_core_n = rsync_q[RST_STAGES-1];

  // stage 1: capture
  logic              v1, k1;
  logic [BYTE_W-1:0] d1;

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      v1 <= 1'b0;
      k1 <= 1'b0;
      d1 <= '0;
    end else begin
      v1 <= valid_i;
      if (valid_i) begin
        k1 <= ctrl_i;
        d1 <= data_i;
      end
    end
  end

  // stage 2: lookups and ones-heavy disparity
  pos_word_t pw_c, pw2;
  logic      v2;

  pse_lookup u_lookup (
    .byte_i (d1),
    .ctrl_i (k1),
    .pw_o   (pw_c)
  );

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      v2  <= 1'b0;
      pw2 <= '0;
    end else begin
      v2 <= v1;
      if (v1) pw2 <= pw_c;
    end
  end

  // stage 3: polarity choice and running disparity
  logic [CODE_W-1:0] code_c, code3;
  rd_t               rd_c, rd3;
  logic              v3;

  pse_rd_track u_rd (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .en_i      (v2),
    .init_i    (rd_init_i),
    .pw_i      (pw2),
    .code_o    (code_c),
    .rd_next_o (rd_c)
  );

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      v3    <= 1'b0;
      code3 <= '0;
      rd3   <= RD_ZERO;
    end else begin
      v3 <= v2;
      if (v2) begin
        code3 <= code_c;
        rd3   <= rd_c;
      end
    end
  end

  // stage 4: output
  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      valid_o <= 1'b0;
      code_o  <= '0;
      rd_o    <= RD_ZERO;
    end else begin
      valid_o <= v3;
      if (v3) begin
        code_o <= code3;
        rd_o   <= rd3;
      end
    end
  end

  // assertion support: edges since the core left reset, saturating
  logic [2:0] up_cnt;
  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n)          up_cnt <= '0;
    else if (up_cnt != 3'd4)  up_cnt <= up_cnt + 3'd1;
  end

  AST_FIXED_LATENCY: assert property (@(posedge clk) disable iff (!rst_core_n)
    (up_cnt == 3'd4) |-> (valid_o == $past(valid_i, 4)))
    else $error("latency broken"); // R2

  AST_BUBBLE_HOLD: assert property (@(posedge clk) disable iff (!rst_core_n)
    (up_cnt != 3'd0 && !valid_o) |-> ($stable(rd_o) && $stable(code_o)))
    else $error("bubble changed outputs"); // R9

  AST_RD_STEP: assert property (@(posedge clk) disable iff (!rst_core_n)
    (up_cnt != 3'd0 && valid_o && $past(valid_o)) |->
      ((int'(rd_o) - int'($past(rd_o))) == ($countones(code_o) - 5)))
    else $error("running disparity step wrong"); // R3

  AST_POLARITY: assert property (@(posedge clk) disable iff (!rst_core_n)
    (up_cnt != 3'd0 && valid_o && $past(valid_o)) |->
      ($past(rd_o[1]) ? ($countones(code_o) <= 5) : ($countones(code_o) >= 5)))
    else $error("word polarity wrong"); // R4

  AST_SUBBLK_DISP: assert property (@(posedge clk) disable iff (!rst_core_n)
    valid_o |-> ($countones(code_o[CODE_W-1:SUB4_W]) inside {[1:5]} &&
                 $countones(code_o[SUB4_W-1:0]) inside {[1:3]}))
    else $error("sub-block disparity illegal"); // R10

endmodule

// File: tb/pse_encoder_bench.sv
`timescale 1ns/1ps
module pse_encoder_bench;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       valid_i, ctrl_i;
  logic [7:0] data_i;
  logic [1:0] rd_init_i;
  logic       valid_o;
  logic [9:0] code_o;
  logic [1:0] rd_o;

  always #2 clk = ~clk;

  pse_encoder u_pse_encoder (
    .clk       (clk),
    .rst_n     (rst_n),
    .valid_i   (valid_i),
    .ctrl_i    (ctrl_i),
    .data_i    (data_i),
    .rd_init_i (rd_init_i),
    .valid_o   (valid_o),
    .code_o    (code_o),
    .rd_o      (rd_o)
  );

  int          checks = 0;
  int          errors = 0;
  int          ex_rd;
  logic [9:0]  last_code;
  logic [1:0]  last_rd;
  logic [7:0]  q_d[$];
  logic        q_k[$];
  logic        q_v[$];
  int unsigned rng = 32'h1234_5678;

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] nthw(int nb, int wt, int idx);
    int seen = 0;
    logic [7:0] r = '0;
    for (int v = 0; v < (1 << nb); v++) begin
      if ($countones(v[7:0]) == wt) begin
        if (seen == idx) r = v[7:0];
        seen++;
      end
    end
    return r;
  endfunction

  function automatic int unsigned next_rand();
    rng ^= rng << 13;
    rng ^= rng >> 17;
    rng ^= rng << 5;
    return rng;
  endfunction

  task automatic push(logic [7:0] d, logic k, logic v);
    q_d.push_back(d);
    q_k.push_back(k);
    q_v.push_back(v);
  endtask

  task automatic check_one(logic v, logic [7:0] d, logic k);
    logic [5:0] e6;
    logic [3:0] e4;
    logic [1:0] erd;
    string      t6, t4;
    int         lo, hi, n, c;
    bit         neg;
    if (!v) begin
      chk(valid_o == 1'b0, "R9", valid_o, 0);
      chk(code_o == last_code, "R9", code_o, last_code);
      chk(rd_o == last_rd, "R9", rd_o, last_rd);
      return;
    end
    lo = int'(d[4:0]);
    hi = int'(d[7:5]);
    c  = int'(d[2:0]);
    if (k) begin
      e6 = ~nthw(6, 4, 8 + c / 4);
      e4 = nthw(4, 3, c % 4);
      t6 = "R8";
      t4 = "R8";
    end else if (lo >= 28) begin
      n  = (lo - 28) * 8 + hi;
      e6 = nthw(6, 5, n / 6);
      e4 = nthw(4, 2, n % 6);
      t6 = "R7";
      t4 = "R7";
    end else begin
      e6 = (lo < 20) ? nthw(6, 3, lo) : nthw(6, 4, lo - 20);
      e4 = (hi < 6) ? nthw(4, 2, hi) : nthw(4, 3, hi - 6);
      t6 = "R5";
      t4 = "R6";
    end
    neg = (ex_rd > 0);
    if (neg && $countones(e6) != 3) e6 = ~e6;
    if (neg && $countones(e4) != 2) e4 = ~e4;
    ex_rd = ex_rd + 2 * $countones({e6, e4}) - 10;
    erd   = 2'((ex_rd + 2) / 2);
    chk(valid_o == 1'b1, "R2", valid_o, 1);
    chk(code_o[9:4] == e6, t6, code_o[9:4], e6);
    chk(code_o[3:0] == e4, t4, code_o[3:0], e4);
    chk(rd_o == erd, "R3", rd_o, erd);
    chk(neg ? ($countones(code_o) <= 5) : ($countones(code_o) >= 5), "R4",
        $countones(code_o), 5);
    chk($countones(code_o[9:4]) inside {[1:5]} && $countones(code_o[3:0]) inside {[1:3]},
        "R10", code_o, {e6, e4});
    chk(ex_rd >= -2 && ex_rd <= 4, "R10", ex_rd, 0);
    last_code = code_o;
    last_rd   = rd_o;
  endtask

  task automatic run_seq();
    int n = q_d.size();
    for (int j = 0; j < n + 4; j++) begin
      @(negedge clk);
      if (j >= 4) check_one(q_v[j-4], q_d[j-4], q_k[j-4]);
      if (j < n) begin
        valid_i = q_v[j];
        data_i  = q_d[j];
        ctrl_i  = q_k[j];
      end else begin
        valid_i = 1'b0;
      end
    end
    q_d.delete();
    q_k.delete();
    q_v.delete();
  endtask

  task automatic do_reset(logic [1:0] init);
    @(negedge clk);
    rst_n     = 1'b0;
    valid_i   = 1'b0;
    ctrl_i    = 1'b0;
    data_i    = '0;
    rd_init_i = init;
    repeat (3) @(negedge clk);
    chk(valid_o == 1'b0, "R1", valid_o, 0);
    chk(code_o == 10'd0, "R1", code_o, 0);
    chk(rd_o == 2'b01, "R1", rd_o, 1);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    ex_rd     = 2 * int'(init) - 2;
    last_code = '0;
    last_rd   = 2'b01;
  endtask

  task automatic t_reset();
    do_reset(2'b01);
  endtask

  task automatic t_latency();
    do_reset(2'b01);
    @(negedge clk);
    valid_i = 1'b1;
    ctrl_i  = 1'b0;
    data_i  = 8'h03;
    for (int j = 1; j <= 6; j++) begin
      @(negedge clk);
      valid_i = 1'b0;
      if (j == 4) check_one(1'b1, 8'h03, 1'b0);
      else        chk(valid_o == 1'b0, "R2", valid_o, 0);
    end
  endtask

  task automatic t_data_sweep();
    do_reset(2'b01);
    for (int b = 0; b < 256; b++) push(8'(b), 1'b0, 1'b1);
    run_seq();
  endtask

  task automatic t_ctrl();
    do_reset(2'b00);
    for (int c = 0; c < 8; c++) begin
      push(8'h14, 1'b0, 1'b1);
      push({5'(c * 5 + 3), 3'(c)}, 1'b1, 1'b1);
      push(8'h1F, 1'b0, 1'b1);
      push({5'(c * 11 + 17), 3'(c)}, 1'b1, 1'b1);
    end
    run_seq();
  endtask

  task automatic t_gaps();
    do_reset(2'b10);
    for (int j = 0; j < 48; j++) push(8'(j * 37 + 20), 1'(j % 5 == 0), 1'(j % 3 != 0));
    run_seq();
  endtask

  task automatic t_init();
    for (int i = 0; i < 4; i++) begin
      do_reset(2'(i));
      push(8'h14, 1'b0, 1'b1);
      push(8'h1F, 1'b0, 1'b1);
      push(8'hE0, 1'b0, 1'b1);
      push(8'h05, 1'b1, 1'b1);
      run_seq();
    end
  endtask

  task automatic t_random();
    do_reset(2'b11);
    for (int j = 0; j < 3000; j++) begin
      int unsigned r = next_rand();
      push(r[7:0], r[10:8] == 3'd0, r[13:12] != 2'b00);
    end
    run_seq();
  endtask

  initial begin
    #(4 * 150000);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n     = 1'b0;
    valid_i   = 1'b0;
    ctrl_i    = 1'b0;
    data_i    = '0;
    rd_init_i = 2'b01;
    t_reset();
    t_latency();
    t_data_sweep();
    t_ctrl();
    t_gaps();
    t_init();
    t_random();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule